// File: doc/BRIEF.md
# Fast-Link Byte FIFO Status Unit

This block sits between a host register port and a card-side byte engine. It holds two byte queues. The inbound queue carries bytes from the card to the host and holds 512 entries. The outbound queue carries bytes from the host to the card and holds 256 entries. The host reads one packed status byte and picks a transfer style from it. The first choice is a burst of a full queue-sized block. The second is a burst of whatever bytes remain. The third is single-byte transfers.

The host port is a 5-bit offset with separate read and write strobes and 8-bit data. Read data is combinational and follows the offset. An identification register tells software whether the fast path exists. A master interrupt gate raises an interrupt line while inbound data waits. A configuration-reset write empties both queues and closes the gate. On the card side, a valid/ready stream fills the inbound queue and a pop-driven stream drains the outbound queue.

Top module: `fastlink_fifo_status`

## Requirements
- R1: After reset, the status byte is 0x78, irq is low, out_valid is low and in_ready is high.
- R2: In the status byte at offset 0x06, the inbound flags are as follows. Bit 0 is ready (occupancy at least 1). Bit 1 is half (occupancy at least 256). Bit 2 is full (occupancy 512). Bit 3 is empty (occupancy 0).
- R3: In the same byte, the outbound flags are as follows. Bit 4 is ready (at least 1 free slot). Bit 5 is half (at least 128 free slots). Bit 6 is empty (no bytes held). Bit 7 is full (256 bytes held).
- R4: A host read at offset 0x00 returns the oldest inbound byte and removes it, so bytes leave in arrival order. A read at 0x00 while the inbound queue is empty returns 0x00 and leaves the occupancy unchanged.
- R5: in_ready is low exactly when the inbound queue is full, and a card push while it is full is dropped.
- R6: A host write at offset 0x01 appends to the outbound queue. The card drains it in order through out_pop. A write while the queue is full is dropped.
- R7: A read at offset 0x17 returns 0x83 when FAST_LINK is 1, which equals 1 once bits 7 and 1 are masked off. It returns 0x08 otherwise.
- R8: Writing 0x0F to offset 0x1F empties both queues and clears the interrupt enable. Any other value written there has no effect.
- R9: A write to offset 0x12 sets the interrupt enable to bit 3 of the data, so 0x08 enables and 0x00 disables. irq is high when the enable is set and the inbound queue holds at least one byte.
- R10: A card push and a host read of the inbound queue in the same cycle leave the occupancy unchanged and keep the byte order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_addr | input | 5 | Host register offset |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe (pops at offset 0x00) |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data, combinational |
| in_valid | input | 1 | Card pushes a byte into the inbound queue |
| in_data | input | 8 | Card inbound byte |
| in_ready | output | 1 | Inbound queue has a free slot |
| out_pop | input | 1 | Card takes the head outbound byte |
| out_valid | output | 1 | Outbound queue holds a byte |
| out_data | output | 8 | Head outbound byte |
| irq | output | 1 | Interrupt request |

## Verification
The assertions check these behaviours on every cycle:
- The inbound occupancy never exceeds its depth.
- A full queue stays unchanged under a dropped push.
- An empty read returns zero and leaves the queue alone.
- The configuration reset empties both queues and silences the interrupt.
- The interrupt never fires over an empty queue.

Only the bench scenarios show the rest: the exact flag thresholds at each fill level, byte ordering through both queues, the identification value, and the fact that other configuration-reset values are ignored.

// File: rtl/fastlink_fifo_status.sv
module fastlink_fifo_status #(
  parameter int IN_DEPTH  = 512,
  parameter int OUT_DEPTH = 256,
  parameter bit FAST_LINK = 1'b1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [4:0] host_addr,
  input  logic       host_wr,
  input  logic       host_rd,
  input  logic [7:0] host_wdata,
  output logic [7:0] host_rdata,
  input  logic       in_valid,
  input  logic [7:0] in_data,
  output logic       in_ready,
  input  logic       out_pop,
  output logic       out_valid,
  output logic [7:0] out_data,
  output logic       irq
);
  localparam int IAW = $clog2(IN_DEPTH);
  localparam int OAW = $clog2(OUT_DEPTH);
  localparam int ICW = $clog2(IN_DEPTH + 1);
  localparam int OCW = $clog2(OUT_DEPTH + 1);
  localparam logic [4:0] OFS_RXDATA = 5'h00;
  localparam logic [4:0] OFS_TXDATA = 5'h01;
  localparam logic [4:0] OFS_STATUS = 5'h06;
  localparam logic [4:0] OFS_IRQGATE = 5'h12;
  localparam logic [4:0] OFS_IDENT = 5'h17;
  localparam logic [4:0] OFS_CFGRST = 5'h1F;
  localparam logic [7:0] IDENT_VAL = FAST_LINK ? 8'h83 : 8'h08;

  logic [7:0]     in_mem  [IN_DEPTH];
  logic [7:0]     out_mem [OUT_DEPTH];
  logic [IAW-1:0] in_wp, in_rp;
  logic [OAW-1:0] out_wp, out_rp;
  logic [ICW-1:0] in_cnt;
  logic [OCW-1:0] out_cnt, out_free;
  logic           irq_en;

  wire flush   = host_wr && host_addr == OFS_CFGRST && host_wdata == 8'h0F;
  wire in_full = in_cnt == ICW'(IN_DEPTH);
  wire in_emp  = in_cnt == '0;
  wire out_full = out_cnt == OCW'(OUT_DEPTH);
  wire out_emp = out_cnt == '0;
  wire in_push = in_valid && !in_full;
  wire in_pop  = host_rd && host_addr == OFS_RXDATA && !in_emp;
  wire out_push = host_wr && host_addr == OFS_TXDATA && !out_full;
  wire out_take = out_pop && !out_emp;

  assign out_free  = OCW'(OUT_DEPTH) - out_cnt;
  assign in_ready  = !in_full;
  assign out_valid = !out_emp;
  assign out_data  = out_mem[out_rp];
  assign irq       = irq_en && !in_emp;

  wire [7:0] status = {out_full, out_emp, out_free >= OCW'(OUT_DEPTH / 2), !out_full,
                       in_emp, in_full, in_cnt >= ICW'(IN_DEPTH / 2), !in_emp};

  always_ff @(posedge clk) begin
    if (in_push) in_mem[in_wp] <= in_data;
    if (out_push) out_mem[out_wp] <= host_wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      in_wp <= '0; in_rp <= '0; in_cnt <= '0;
      out_wp <= '0; out_rp <= '0; out_cnt <= '0;
    end else begin
      if (in_push) in_wp <= in_wp + IAW'(1);
      if (in_pop) in_rp <= in_rp + IAW'(1);
      in_cnt <= in_cnt + ICW'(in_push) - ICW'(in_pop);
      if (out_push) out_wp <= out_wp + OAW'(1);
      if (out_take) out_rp <= out_rp + OAW'(1);
      out_cnt <= out_cnt + OCW'(out_push) - OCW'(out_take);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || flush) irq_en <= 1'b0;
    else if (host_wr && host_addr == OFS_IRQGATE) irq_en <= host_wdata[3];
  end

  always_comb begin
    case (host_addr)
      OFS_RXDATA: host_rdata = in_emp ? 8'h00 : in_mem[in_rp];
      OFS_STATUS: host_rdata = status;
      OFS_IDENT:  host_rdata = IDENT_VAL;
      default:    host_rdata = 8'h00;
    endcase
  end
endmodule

// File: rtl/fastlink_fifo_status_chk.sv
module fastlink_fifo_status_chk #(
  parameter int IN_DEPTH  = 512,
  parameter int OUT_DEPTH = 256
) (
  input logic                           clk,
  input logic                           rst_n,
  input logic [4:0]                     host_addr,
  input logic                           host_wr,
  input logic                           host_rd,
  input logic [7:0]                     host_wdata,
  input logic [7:0]                     host_rdata,
  input logic                           in_valid,
  input logic                           in_ready,
  input logic                           out_pop,
  input logic                           out_valid,
  input logic                           irq,
  input logic [$clog2(IN_DEPTH+1)-1:0]  in_cnt,
  input logic [$clog2(OUT_DEPTH+1)-1:0] out_cnt
);
  localparam int ICW = $clog2(IN_DEPTH + 1);
  localparam int OCW = $clog2(OUT_DEPTH + 1);
  wire cfg_hit = host_wr && host_addr == 5'h1F && host_wdata == 8'h0F;
  wire rx_rd   = host_rd && host_addr == 5'h00;

  assert_in_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    in_cnt <= ICW'(IN_DEPTH));
  assert_in_drop_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_ready && !rx_rd && !cfg_hit) |=> in_cnt == $past(in_cnt));
  assert_in_ready_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ready |-> in_cnt == ICW'(IN_DEPTH));
  assert_empty_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_rd && in_cnt == '0) |-> host_rdata == 8'h00);
  assert_empty_keep_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_rd && in_cnt == '0 && !in_valid && !cfg_hit) |=> in_cnt == '0);
  assert_out_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && host_addr == 5'h01 && out_cnt == OCW'(OUT_DEPTH) && !out_pop)
      |=> out_cnt == OCW'(OUT_DEPTH));
  assert_out_valid_R6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_cnt != '0);
  assert_cfg_flush_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_hit |=> (in_cnt == '0 && out_cnt == '0 && !irq));
  assert_irq_data_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> in_cnt != '0);
endmodule

bind fastlink_fifo_status fastlink_fifo_status_chk #(.IN_DEPTH(IN_DEPTH), .OUT_DEPTH(OUT_DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wr(host_wr), .host_rd(host_rd),
  .host_wdata(host_wdata), .host_rdata(host_rdata), .in_valid(in_valid), .in_ready(in_ready),
  .out_pop(out_pop), .out_valid(out_valid), .irq(irq), .in_cnt(in_cnt), .out_cnt(out_cnt)
);

// File: tb/fastlink_fifo_status_test.sv
`timescale 1ns/1ps
module fastlink_fifo_status_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [4:0] host_addr = '0;
  logic host_wr = 1'b0, host_rd = 1'b0;
  logic [7:0] host_wdata = '0;
  logic [7:0] host_rdata;
  logic in_valid = 1'b0;
  logic [7:0] in_data = '0;
  logic in_ready, out_pop = 1'b0, out_valid, irq;
  logic [7:0] out_data;
  int total = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  fastlink_fifo_status uut (
    .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wr(host_wr), .host_rd(host_rd),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .out_pop(out_pop), .out_valid(out_valid), .out_data(out_data), .irq(irq)
  );

  localparam int NV = 6;
  localparam int VIN  [NV] = '{0, 1, 255, 256, 511, 512};
  localparam int VOUT [NV] = '{0, 1, 128, 129, 255, 256};
  localparam logic [7:0] VSTAT [NV] = '{8'h78, 8'h31, 8'h31, 8'h13, 8'h13, 8'h87};

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic hwrite(logic [4:0] a, logic [7:0] d);
    host_addr = a; host_wdata = d; host_wr = 1'b1;
    @(posedge clk); @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic hread(logic [4:0] a, output logic [7:0] d);
    host_addr = a; host_rd = 1'b1;
    #2 d = host_rdata;
    @(posedge clk); @(negedge clk);
    host_rd = 1'b0;
  endtask

  task automatic push(logic [7:0] d);
    in_valid = 1'b1; in_data = d;
    @(posedge clk); @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic pop(output logic [7:0] d);
    d = out_data; out_pop = 1'b1;
    @(posedge clk); @(negedge clk);
    out_pop = 1'b0;
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    hread(5'h06, d); check("R1 status", d, 8'h78);
    check("R1 irq/valid/ready", {5'b0, irq, out_valid, in_ready}, 8'h01);

    // R2 R3 fill-level vectors, each after a configuration reset (R8)
    for (int v = 0; v < NV; v++) begin
      hwrite(5'h1F, 8'h0F);
      for (int k = 0; k < 512; k++) begin
        if (k >= VIN[v] && k >= VOUT[v]) break;
        in_valid = k < VIN[v]; in_data = k[7:0];
        host_wr = k < VOUT[v]; host_addr = 5'h01; host_wdata = k[7:0];
        @(posedge clk); @(negedge clk);
        in_valid = 1'b0; host_wr = 1'b0;
      end
      hread(5'h06, d);
      check($sformatf("R2 R3 status fill %0d/%0d", VIN[v], VOUT[v]), d, VSTAT[v]);
    end

    // R5 full inbound (512 held) drops a push; R6 full outbound drops a write
    check("R5 in_ready when full", {7'b0, in_ready}, 8'h00);
    push(8'hEE);
    hwrite(5'h01, 8'hEE);
    hread(5'h00, d); check("R4 first byte of full queue", d, 8'h00);
    hread(5'h06, d); check("R5 extra push dropped", d[3:0], 4'h3);
    for (int k = 0; k < 256; k++) begin
      pop(d);
      if (k == 255) check("R6 last outbound byte not the dropped one", d, 8'hFF);
    end
    check("R6 outbound drained", {7'b0, out_valid}, 8'h00);

    // R8 flush, then wrong config value has no effect
    hwrite(5'h1F, 8'h0F);
    push(8'h11);
    hwrite(5'h01, 8'h22);
    hwrite(5'h1F, 8'h0E);
    hread(5'h06, d); check("R8 other value ignored", d, 8'h31);
    hwrite(5'h1F, 8'h0F);
    hread(5'h06, d); check("R8 flush empties", d, 8'h78);

    // R4 order and empty read
    push(8'hA1); push(8'hB2); push(8'hC3);
    hread(5'h00, d); check("R4 order 1", d, 8'hA1);
    hread(5'h00, d); check("R4 order 2", d, 8'hB2);
    hread(5'h00, d); check("R4 order 3", d, 8'hC3);
    hread(5'h00, d); check("R4 empty read", d, 8'h00);
    push(8'h5A);
    hread(5'h00, d); check("R4 empty read moved nothing", d, 8'h5A);

    // R10 simultaneous push and pop
    push(8'h01);
    in_valid = 1'b1; in_data = 8'h02; host_addr = 5'h00; host_rd = 1'b1;
    #2 d = host_rdata;
    @(posedge clk); @(negedge clk);
    in_valid = 1'b0; host_rd = 1'b0;
    check("R10 popped head", d, 8'h01);
    hread(5'h06, d); check("R10 occupancy kept", d[3:0], 4'h1);
    hread(5'h00, d); check("R10 order kept", d, 8'h02);

    // R6 outbound order
    hwrite(5'h01, 8'h10); hwrite(5'h01, 8'h20);
    pop(d); check("R6 out order 1", d, 8'h10);
    pop(d); check("R6 out order 2", d, 8'h20);

    // R7 identification
    hread(5'h17, d); check("R7 ident raw", d, 8'h83);
    check("R7 ident masked", d & ~8'h82, 8'h01);

    // R9 interrupt gate
    push(8'h33);
    check("R9 irq disabled", {7'b0, irq}, 8'h00);
    hwrite(5'h12, 8'h08);
    check("R9 irq enabled", {7'b0, irq}, 8'h01);
    hread(5'h00, d);
    check("R9 irq empty", {7'b0, irq}, 8'h00);
    push(8'h34);
    hwrite(5'h12, 8'h00);
    check("R9 irq masked", {7'b0, irq}, 8'h00);
    hwrite(5'h12, 8'h08);
    hwrite(5'h1F, 8'h0F);
    push(8'h35);
    check("R8 flush clears enable", {7'b0, irq}, 8'h00);

    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule